// File: doc/BRIEF.md
# Serial Interrupt Identification Encoder

This block sits beside the register file of a byte-oriented serial controller. Each clock cycle it looks at four interrupt causes and the enable mask that software has programmed. Among the causes that are both active and enabled, it chooses the one with the highest priority and publishes it as an 8-bit identification code. It also drives a single interrupt request line toward the system interrupt controller.

The causes, from highest to lowest priority, are a receive error, a received byte waiting, an empty transmit holding register, and a change on a modem line. The block keeps no pending state of its own. The code is rebuilt every cycle from the live status inputs, so a cause disappears from the output as soon as the register logic elsewhere clears its status bit. The decision is held in one output register, which gives one cycle of latency from input to output.

Top module: `irq_id_encoder`

## Requirements
- R1: While `rst_n` is low, `id_code` is 0x01 and `irq` is 0.
- R2: If no cause is both active and enabled, `id_code` is 0x01 ("nothing pending").
- R3: The receive-error cause is active when any bit of `line_err` is set (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). It is enabled by `int_en[2]`, has the highest priority, and yields code 0x06.
- R4: The received-byte cause is active when `rx_ready` is 1. It is enabled by `int_en[0]`, is second in priority, and yields code 0x04.
- R5: The transmit-empty cause is active when `tx_empty` is 1. It is enabled by `int_en[1]`, is third in priority, and yields code 0x02.
- R6: The modem-change cause is active when any bit of `modem_delta` is set. It is enabled by `int_en[3]`, has the lowest priority, and yields code 0x00.
- R7: `irq` is 1 exactly when bit 0 of `id_code` is 0, in the same cycle.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. When a cause goes away, the next lower cause, or 0x01 if there is none, is shown one cycle later.
- R9: An active cause whose enable bit is 0 has no effect on `id_code` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_en | input | 4 | Enable mask: bit0 rx byte, bit1 tx empty, bit2 rx error, bit3 modem change |
| line_err | input | 4 | Receive error flags: overrun, parity, framing, break |
| rx_ready | input | 1 | A received byte is waiting |
| tx_empty | input | 1 | The transmit holding register is empty |
| modem_delta | input | 4 | Modem line change flags |
| id_code | output | 8 | Identification code of the winning cause |
| irq | output | 1 | Interrupt request |

## Verification
The main collision is between the priority choice and the enable gating. Several causes are active in the same cycle, and some of them are masked off. The bench provokes this with random cause and mask patterns plus directed vectors in which a masked high-priority cause sits on top of an enabled lower one. It judges the result against an ordered if-chain model. A second collision is one cause dropping in the same cycle that another rises. Here the bench checks that the output follows the new cause exactly one cycle later and never shows a stale code.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
    localparam int ID_W    = 8;
    localparam int NUM_LVL = 4;
    localparam int EN_W    = 4;
    localparam int ERR_W   = 4;
    localparam int DLT_W   = 4;

    localparam logic [ID_W-1:0] CODE_NONE = 8'h01;

    // priority level 0 is the highest
    localparam int LVL_ERR   = 0;
    localparam int LVL_RXB   = 1;
    localparam int LVL_TXE   = 2;
    localparam int LVL_MODEM = 3;

    function automatic int lvl_en_bit(input int lvl);
        case (lvl)
            LVL_ERR:   return 2;
            LVL_RXB:   return 0;
            LVL_TXE:   return 1;
            default:   return 3;
        endcase
    endfunction

    function automatic logic [ID_W-1:0] lvl_code(input int lvl);
        case (lvl)
            LVL_ERR:   return 8'h06;
            LVL_RXB:   return 8'h04;
            LVL_TXE:   return 8'h02;
            default:   return 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            irq;
    } id_out_t;
endpackage

// File: rtl/irq_cause_gate.sv
module irq_cause_gate
    import irq_id_pkg::*;
(
    input  logic [EN_W-1:0]    int_en,
    input  logic [ERR_W-1:0]   line_err,
    input  logic               rx_ready,
    input  logic               tx_empty,
    input  logic [DLT_W-1:0]   modem_delta,
    output logic [NUM_LVL-1:0] pend
);
    logic [NUM_LVL-1:0] cause;

    always_comb begin
        cause            = '0;
        cause[LVL_ERR]   = |line_err;
        cause[LVL_RXB]   = rx_ready;
        cause[LVL_TXE]   = tx_empty;
        cause[LVL_MODEM] = |modem_delta;
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam int EB = lvl_en_bit(g);
        assign pend[g] = cause[g] & int_en[EB];
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_id_pkg::*;
(
    input  logic [NUM_LVL-1:0] pend,
    output logic [NUM_LVL-1:0] grant,
    output logic               any
);
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (pend[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end

    // at most one level wins (R3..R6)
    always_comb begin
        p_grant_onehot_r3: assert ($onehot0(grant));
    end
endmodule

// File: rtl/irq_code_map.sv
module irq_code_map
    import irq_id_pkg::*;
(
    input  logic [NUM_LVL-1:0] grant,
    input  logic               any,
    output logic [ID_W-1:0]    code
);
    always_comb begin
        code = CODE_NONE;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (grant[i]) code = lvl_code(i);
        end
        if (!any) code = CODE_NONE;
    end
endmodule

// File: rtl/irq_id_encoder.sv
module irq_id_encoder
    import irq_id_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EN_W-1:0]    int_en,
    input  logic [ERR_W-1:0]   line_err,
    input  logic               rx_ready,
    input  logic               tx_empty,
    input  logic [DLT_W-1:0]   modem_delta,
    output logic [ID_W-1:0]    id_code,
    output logic               irq
);
    logic [NUM_LVL-1:0] pend;
    logic [NUM_LVL-1:0] grant;
    logic               any;
    logic [ID_W-1:0]    code;
    id_out_t            out_d, out_q;

    irq_cause_gate i_gate (
        .int_en     (int_en),
        .line_err   (line_err),
        .rx_ready   (rx_ready),
        .tx_empty   (tx_empty),
        .modem_delta(modem_delta),
        .pend       (pend)
    );

    irq_prio_pick i_pick (
        .pend (pend),
        .grant(grant),
        .any  (any)
    );

    irq_code_map i_map (
        .grant(grant),
        .any  (any),
        .code (code)
    );

    always_comb begin
        out_d     = out_q;
        out_d.id  = code;
        out_d.irq = any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.id  <= CODE_NONE;
            out_q.irq <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign id_code = out_q.id;
    assign irq     = out_q.irq;

    p_irq_vs_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !id_code[0]);

    p_err_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en[2] && |line_err) |=> id_code == 8'h06);

    p_rxb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en[0] && rx_ready && !(int_en[2] && |line_err)) |=> id_code == 8'h04);

    p_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !((int_en[2] && |line_err) || (int_en[0] && rx_ready) ||
          (int_en[1] && tx_empty) || (int_en[3] && |modem_delta))
        |=> (id_code == 8'h01 && !irq));

    p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 4'b0000) |=> !irq);
endmodule

// File: tb/test_irq_id_encoder.sv
`timescale 1ns/1ps
module test_irq_id_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] int_en = '0;
    logic [3:0] line_err = '0;
    logic       rx_ready = 1'b0;
    logic       tx_empty = 1'b0;
    logic [3:0] modem_delta = '0;
    logic [7:0] id_code;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_id = 8'h01;
    string      exp_tag = "R1";

    always #5 clk = ~clk;

    irq_id_encoder i_irq_id_encoder (
        .clk(clk), .rst_n(rst_n), .int_en(int_en), .line_err(line_err),
        .rx_ready(rx_ready), .tx_empty(tx_empty), .modem_delta(modem_delta),
        .id_code(id_code), .irq(irq)
    );

    function automatic int model(input logic [3:0] en, input logic [3:0] err,
                                 input logic rdy, input logic emp, input logic [3:0] dlt);
        if (en[2] && err != 0) return 'h06;
        else if (en[0] && rdy) return 'h04;
        else if (en[1] && emp) return 'h02;
        else if (en[3] && dlt != 0) return 'h00;
        return 'h01;
    endfunction

    function automatic string tag_of(input int c);
        case (c)
            'h06: return "R3";
            'h04: return "R4";
            'h02: return "R5";
            'h00: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic check_now();
        n_tests++;
        if (id_code !== exp_id) begin
            n_fail++;
            $display("FAIL %s id_code actual=%02h expected=%02h", exp_tag, id_code, exp_id);
        end
        n_tests++;
        if (irq !== !exp_id[0]) begin
            n_fail++;
            $display("FAIL R7 irq actual=%0b expected=%0b", irq, !exp_id[0]);
        end
    endtask

    // check result of previous vector at negedge, then apply the next one
    task automatic step(input logic [3:0] en, input logic [3:0] err, input logic rdy,
                        input logic emp, input logic [3:0] dlt, input string tag);
        @(negedge clk);
        check_now();
        int_en = en; line_err = err; rx_ready = rdy; tx_empty = emp; modem_delta = dlt;
        exp_id = 8'(model(en, err, rdy, emp, dlt));
        exp_tag = (tag == "") ? tag_of(exp_id) : tag;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, with causes active and enabled during reset
        int_en = 4'hF; line_err = 4'h1; rx_ready = 1'b1;
        repeat (3) @(negedge clk);
        exp_id = 8'h01; exp_tag = "R1";
        check_now();
        int_en = '0; line_err = '0; rx_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_id = 8'h01; exp_tag = "R2";

        // R2 nothing pending
        step(4'h0, 4'h0, 0, 0, 4'h0, "R2");
        // R3 each error bit alone, with everything else also active
        for (int b = 0; b < 4; b++) step(4'hF, 4'(1 << b), 1, 1, 4'hF, "R3");
        // R4 over R5 and R6
        step(4'hF, 4'h0, 1, 1, 4'h3, "R4");
        // R5 over R6
        step(4'hF, 4'h0, 0, 1, 4'h8, "R5");
        // R6 each delta bit
        for (int b = 0; b < 4; b++) step(4'h8, 4'h0, 0, 0, 4'(1 << b), "R6");
        // R9 masked higher causes fall through
        step(4'b1011, 4'hF, 1, 1, 4'h1, "R9");
        step(4'b1010, 4'hF, 1, 1, 4'h1, "R9");
        step(4'b1000, 4'hF, 1, 1, 4'h1, "R9");
        step(4'b0111, 4'h0, 0, 0, 4'hF, "R9");
        step(4'b0000, 4'hF, 1, 1, 4'hF, "R9");
        // R8 causes dropping and rising one per cycle
        step(4'hF, 4'h2, 1, 1, 4'h1, "R8");
        step(4'hF, 4'h0, 1, 1, 4'h1, "R8");
        step(4'hF, 4'h0, 0, 1, 4'h1, "R8");
        step(4'hF, 4'h0, 0, 0, 4'h1, "R8");
        step(4'hF, 4'h0, 0, 0, 4'h0, "R8");
        step(4'hF, 4'h4, 0, 0, 4'h0, "R8");
        step(4'hF, 4'h0, 0, 0, 4'h0, "R8");
        // random mixes
        for (int k = 0; k < 400; k++)
            step(4'($urandom), 4'($urandom) & 4'($urandom), 1'($urandom),
                 1'($urandom), 4'($urandom) & 4'($urandom), "");
        @(negedge clk);
        check_now();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule